// File: doc/BRIEF.md
# Byte-Lane Static RAM with Power-Down Decode

This block is a single-port static RAM of 16-bit words. It is split into a low byte lane and a high byte lane. The control inputs are all active low: a chip select, a write strobe, a read strobe and one enable for each byte lane. Each cycle, these inputs are decoded into one of four outcomes: write, read, idle, or sleep. The address and write data sit on plain pins. A write is taken on the rising clock edge and updates only the lanes whose enable is low. A read is combinational and follows the address at once.

The shared data bus is split into three parts so that it can be synthesized. These are an input word, an output word, and one output-enable bit per lane. An integrating level can join them into a tri-state pad. A lane whose output enable is low carries zero on its output bits. A sleep flag reports when the part is deselected. Either chip select high or both lane enables high counts as deselected. No access of any kind takes place during sleep.

Depth is set by `ADDR_W`. The full-size configuration is `ADDR_W = 16`, which gives 65,536 words. The default is smaller to keep elaboration light.

Top module: `bls_sram`

## Requirements
- R1: The storage holds 2**ADDR_W words of 16 bits. Bits 7:0 form the low lane and bits 15:8 form the high lane. A read of a word returns, per lane, the byte most recently written to that lane of that word.
- R2: When `ce_n`=0, `we_n`=0 and `sleep`=0 at a rising clock edge, the word at `addr` takes `dq_in` in every lane whose enable is low (`lb_n` for bits 7:0, `ub_n` for bits 15:8).
- R3: During a write, a lane whose enable is high keeps its stored byte.
- R4: When `ce_n`=0, `we_n`=1 and `oe_n`=0, every lane whose enable is low has its `dq_oe` bit (bit 0 low lane, bit 1 high lane) set. That lane's `dq_out` bits show the stored byte at the current `addr` in the same cycle.
- R5: A lane whose `dq_oe` bit is 0 drives 0 on its `dq_out` bits. A lane with its enable high stays undriven even while the other lane is read.
- R6: `dq_oe` is 0 whenever `ce_n`=1, `oe_n`=1, or both lane enables are 1.
- R7: When `ce_n`=0 and `we_n`=0, the cycle is a write and `dq_oe` is 0, whatever the value of `oe_n`.
- R8: `sleep` is 1 exactly when `ce_n`=1, or when both `lb_n` and `ub_n` are 1.
- R9: While `sleep`=1, no stored byte changes, even with `we_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low, wins over `oe_n` |
| oe_n | input | 1 | Read strobe, active low |
| lb_n | input | 1 | Low lane (bits 7:0) enable, active low |
| ub_n | input | 1 | High lane (bits 15:8) enable, active low |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero in undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 low lane |
| sleep | output | 1 | Deselected / powered-down status |

## Verification
Several rules are checked on every cycle. The bus must stay undriven during sleep and during writes, and a driven lane must have its enable low. The sleep flag must agree with the select and lane pins. A lane that is written must read back its new byte on the next edge. A lane that is masked or asleep must keep its byte. Only the bench's scenarios can show that each word keeps its own contents across the whole array. They also show that interleaved lane-only writes merge correctly, and that a read follows an address change in the same cycle. These are compared against a shadow array over directed and random control patterns.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2,
    ACC_SLEEP = 2'd3
  } acc_t;

  typedef struct packed {
    acc_t             kind;
    logic [LANES-1:0] lane_sel;
  } acc_dec_t;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output acc_dec_t         dec
);
  always_comb begin
    dec.lane_sel = ~lane_n;
    if (ce_n || (&lane_n))
      dec.kind = ACC_SLEEP;
    else if (!we_n)
      dec.kind = ACC_WRITE;
    else if (!oe_n)
      dec.kind = ACC_READ;
    else
      dec.kind = ACC_NONE;
  end
endmodule

// File: rtl/bls_lane_mem.sv
module bls_lane_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/bls_sram.sv
module bls_sram
  import bls_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic              sleep
);
  acc_dec_t          dec;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rd_word;

  bls_decode u_dec (
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .lane_n ({ub_n, lb_n}),
    .dec    (dec)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = (dec.kind == ACC_WRITE) && dec.lane_sel[g];
    assign dq_oe[g]   = (dec.kind == ACC_READ)  && dec.lane_sel[g];

    bls_lane_mem #(
      .ADDR_W (ADDR_W),
      .DATA_W (LANE_W)
    ) u_mem (
      .clk   (clk),
      .wr_en (lane_we[g]),
      .addr  (addr),
      .wdata (dq_in[g*LANE_W +: LANE_W]),
      .rdata (rd_word[g*LANE_W +: LANE_W])
    );

    assign dq_out[g*LANE_W +: LANE_W] =
      dq_oe[g] ? rd_word[g*LANE_W +: LANE_W] : '0;
  end

  assign sleep = (dec.kind == ACC_SLEEP);
endmodule

// File: rtl/bls_sram_chk.sv
module bls_sram_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [15:0]       dq_in,
  input logic [15:0]       dq_out,
  input logic [1:0]        dq_oe,
  input logic              sleep,
  input logic [1:0]        lane_we,
  input logic [15:0]       rd_word
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R6
  asleep_undriven_chk: assert property (@(posedge clk) disable iff (!armed)
    sleep |-> (dq_oe == 2'b00));
  // R6
  oe_off_undriven_chk: assert property (@(posedge clk) disable iff (!armed)
    oe_n |-> (dq_oe == 2'b00));
  // R7
  write_undriven_chk: assert property (@(posedge clk) disable iff (!armed)
    (!ce_n && !we_n) |-> (dq_oe == 2'b00));
  // R5
  lo_lane_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    dq_oe[0] |-> !lb_n);
  // R5
  hi_lane_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    dq_oe[1] |-> !ub_n);
  // R5
  quiet_lane_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    ((dq_oe[0] || dq_out[7:0] == 8'h00) && (dq_oe[1] || dq_out[15:8] == 8'h00)));
  // R8
  desel_sleep_chk: assert property (@(posedge clk) disable iff (!armed)
    (ce_n || (lb_n && ub_n)) |-> sleep);
  // R8
  awake_chk: assert property (@(posedge clk) disable iff (!armed)
    (!ce_n && !(lb_n && ub_n)) |-> !sleep);
  // R4
  read_data_chk: assert property (@(posedge clk) disable iff (!armed)
    dq_oe[0] |-> (dq_out[7:0] == rd_word[7:0]));
  // R2
  lo_write_land_chk: assert property (@(posedge clk) disable iff (!armed)
    lane_we[0] |=> ((addr != $past(addr)) || (rd_word[7:0] === $past(dq_in[7:0]))));
  // R2
  hi_write_land_chk: assert property (@(posedge clk) disable iff (!armed)
    lane_we[1] |=> ((addr != $past(addr)) || (rd_word[15:8] === $past(dq_in[15:8]))));
  // R3
  lo_masked_keep_chk: assert property (@(posedge clk) disable iff (!armed)
    (!ce_n && !we_n && lb_n) |=> ((addr != $past(addr)) || (rd_word[7:0] === $past(rd_word[7:0]))));
  // R9
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!armed)
    sleep |=> ((addr != $past(addr)) || (rd_word === $past(rd_word))));
endmodule

bind bls_sram bls_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .addr    (addr),
  .ce_n    (ce_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .lb_n    (lb_n),
  .ub_n    (ub_n),
  .dq_in   (dq_in),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe),
  .sleep   (sleep),
  .lane_we (lane_we),
  .rd_word (rd_word)
);

// File: tb/sim_bls_sram.sv
module sim_bls_sram;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out;
  logic [1:0]    dq_oe;
  logic          sleep;

  int checks = 0;
  int fails  = 0;
  logic [15:0] shadow [DEPTH];

  always #10 clk = ~clk;

  bls_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .addr(addr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .lb_n(lb_n), .ub_n(ub_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .sleep(sleep)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, compare mid-low-phase, commit at rising edge
  task automatic cyc(input string tag, input logic c, input logic w, input logic o,
                     input logic l, input logic u, input logic [AW-1:0] a,
                     input logic [15:0] d);
    logic pd, wr, rd;
    logic [1:0] e_oe;
    logic [15:0] e_out;
    @(negedge clk);
    ce_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; dq_in = d;
    #2;
    pd = c || (l && u);
    wr = !c && !w && !pd;
    rd = !c && w && !o && !pd;
    e_oe  = {rd && !u, rd && !l};
    e_out = {e_oe[1] ? shadow[a][15:8] : 8'h00, e_oe[0] ? shadow[a][7:0] : 8'h00};
    check("R8", "sleep", {15'd0, sleep}, {15'd0, pd});
    check(tag, "dq_oe", {14'd0, dq_oe}, {14'd0, e_oe});
    check(tag, "dq_out", dq_out, e_out);
    @(posedge clk);
    if (wr && !l) shadow[a][7:0]  = d[7:0];
    if (wr && !u) shadow[a][15:8] = d[15:8];
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    // Reset state: deselected part reports sleep, bus undriven (R6, R8)
    #2;
    check("R8", "sleep at start", {15'd0, sleep}, 16'd1);
    check("R6", "dq_oe at start", {14'd0, dq_oe}, 16'd0);
    // Fill every word with both lanes (R1, R2)
    for (int i = 0; i < DEPTH; i++)
      cyc("R2", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(i), 16'(i * 16'h9E37 + 16'h1234));
    // Read back all words (R1, R4)
    for (int i = 0; i < DEPTH; i++)
      cyc("R1", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(i), 16'hFFFF);
    // Low-lane-only and high-lane-only writes (R3)
    cyc("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(5), 16'hAB11);
    cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(5), 16'h0);
    cyc("R3", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(6), 16'h22CD);
    cyc("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(6), 16'h0);
    // Single-lane reads keep the other lane undriven (R5)
    cyc("R5", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, AW'(5), 16'h0);
    cyc("R5", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(5), 16'h0);
    // Write priority over read strobe (R7)
    cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(9), 16'h5A5A);
    cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(9), 16'h0);
    // Read strobe high: undriven (R6)
    cyc("R6", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(9), 16'h0);
    // Sleep by chip select and by both lanes off, with write strobe low (R9)
    cyc("R9", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(9), 16'hDEAD);
    cyc("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(9), 16'hBEEF);
    cyc("R9", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(9), 16'h0);
    // Random control mix over a small address window (R1..R9)
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] r;
      r = 6'($urandom);
      cyc("R4", r[0], r[1], r[2], r[3], r[4], AW'($urandom_range(0, 15)), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule